// File: doc/BRIEF.md
# Nonvolatile Memory Write-Unlock Controller

This block is the register front end that stands between a host and an on-chip nonvolatile memory array. The host sees a small byte-wide register space. It contains a control register, a key location that has no storage behind it, a pointer of up to three bytes, and a status byte. A write or erase into the array begins only if the host first writes the byte 0x55 and then the byte 0xAA to the key location, with no other register access between them. The next control-register write must then request a start, and writes must already be enabled at that moment.

The array is modelled as a busy interval of `WR_CYCLES` clocks. During a program-memory operation the block holds the host in a stall for that interval. When the interval ends, the start bit clears and a sticky completion flag rises. There are two resets. A warm reset (external or watchdog) that lands while an operation is running aborts it and sets an error flag. That flag survives warm resets, so software can find the damaged location and write it again.

Top module: `nvm_unlock_ctrl`

## Requirements
- R1: After a power-on reset the control byte, pointer, status byte, stall, completion flag and all array strobes read or drive 0.
- R2: Addresses: 0 control, 1 key, 2..4 pointer low/mid/upper, 5 status. Read data appears one cycle after the read strobe. The key address and control bit 5 always read 0. Pointer bits above bit 21 read 0.
- R3: Control bits are 7 program select, 6 configuration select, 4 erase, 3 error, 2 write enable, 1 start and 0 read start. A start happens only if 0x55 and then 0xAA are written to the key address and the next control write sets bit 1. The start produces a one-cycle `mem_start` pulse, and bit 1 reads 1 while the operation runs.
- R4: A key byte other than the expected one, or a read or write of any non-key address, cancels a partial or complete unlock. A later start request then leaves `mem_start`, the stall and bit 1 at 0.
- R5: Any control write uses up the unlock, so a second start request without a fresh key sequence is ignored.
- R6: A start request is ignored unless write enable was already 1 before that control write. This includes a write that sets enable and start together.
- R7: Bit 1 stays 1 for exactly `WR_CYCLES` cycles after the start edge. With bit 7 = 1, `host_stall` is high for the same cycles. With bit 7 = 0, `host_stall` stays low.
- R8: When an operation ends, `irq_done` and status bit 0 become 1. Writing 1 to status bit 0 clears it. If the clear and the completion land on the same edge, the completion wins.
- R9: A warm reset while an operation is running ends it and sets error bit 3. A warm reset while idle leaves bit 3 unchanged. Writing 0 to bit 3 or a power-on reset clears it, and writing 1 to bit 3 does not set it.
- R10: `mem_addr` is the pointer. `mem_cfg` is control bit 6 OR pointer bit 21. `mem_prog` and `mem_erase` follow bits 7 and 4, which do not change while an operation runs.
- R11: Writing 1 to control bit 0 gives a one-cycle `mem_rd` pulse, and bit 0 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Synchronous power-on reset, active high |
| warm_rst | input | 1 | Synchronous external/watchdog reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| host_stall | output | 1 | Holds the host during a program-memory operation |
| mem_start | output | 1 | One-cycle array operation start |
| mem_rd | output | 1 | One-cycle array read request |
| mem_prog | output | 1 | 1 selects program memory, 0 data memory |
| mem_cfg | output | 1 | Configuration space selected |
| mem_erase | output | 1 | Operation is an erase |
| mem_addr | output | 22 | Array address (pointer) |
| irq_done | output | 1 | Sticky completion flag |

## Verification
Two pairs of events can land on the same edge. The first pair is the end of the busy interval and a software clear of the completion flag. The bench starts a data-memory operation, which does not stall, and writes the status clear timed for the final busy edge. It then expects the flag to read 1. The second pair is the end of the busy interval and a warm reset. A warm reset pulse on that same final edge must set the error bit and must leave the completion flag at 0.

// File: rtl/nvu_pkg.sv
package nvu_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_KEY  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PTR0 = 3'd2;
  localparam int B_RD    = 0;
  localparam int B_WR    = 1;
  localparam int B_WREN  = 2;
  localparam int B_ERR   = 3;
  localparam int B_ERASE = 4;
  localparam int B_CFG   = 6;
  localparam int B_PROG  = 7;
  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  typedef enum logic [1:0] {K_IDLE, K_HALF, K_ARMED} key_st_e;
endpackage

// File: rtl/nvu_key_seq.sv
module nvu_key_seq
  import nvu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic       other_acc,
  input  logic [7:0] key_data,
  output logic       armed
);
  key_st_e st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= K_IDLE;
    end else if (other_acc) begin
      st_q <= K_IDLE;
    end else if (key_wr) begin
      if (st_q == K_IDLE && key_data == KEY_FIRST)       st_q <= K_HALF;
      else if (st_q == K_HALF && key_data == KEY_SECOND) st_q <= K_ARMED;
      else                                               st_q <= K_IDLE;
    end
  end

  assign armed = (st_q == K_ARMED);

  // R3: arming only ever follows the second key byte
  assert_arm_after_second_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(key_wr && key_data == KEY_SECOND));
  // R4: a non-key access always disarms
  assert_other_disarms_R4: assert property (@(posedge clk) disable iff (rst)
    other_acc |=> !armed);
endmodule

// File: rtl/nvu_busy_timer.sv
module nvu_busy_timer #(
  parameter int WR_CYCLES = 20,
  localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic fin
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(WR_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
  assign fin  = busy_q && (cnt_q == '0);

  // R7: the count never leaves its window while busy
  assert_cnt_window_R7: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> (cnt_q < CNT_W'(WR_CYCLES)));
  // R7: no restart while an operation runs
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy_q);
endmodule

// File: rtl/nvm_unlock_ctrl.sv
module nvm_unlock_ctrl
  import nvu_pkg::*;
#(
  parameter int PTR_W     = 22,
  parameter int WR_CYCLES = 20
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              warm_rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              host_stall,
  output logic              mem_start,
  output logic              mem_rd,
  output logic              mem_prog,
  output logic              mem_cfg,
  output logic              mem_erase,
  output logic [PTR_W-1:0]  mem_addr,
  output logic              irq_done
);
  localparam int PB = (PTR_W + 7) / 8;
  localparam int PAD_W = PB * 8;
  localparam logic [ADDR_W-1:0] A_STAT = A_PTR0 + ADDR_W'(PB);
  localparam logic [PAD_W-1:0] PTR_MASK = PAD_W'({PTR_W{1'b1}});

  logic rst_any;
  logic prog_q, cfg_q, erase_q, wren_q, err_q, done_q, stall_q, start_q, rd_q;
  logic [PAD_W-1:0] ptr_q;
  logic [7:0] rd_mux;
  logic armed, busy, fin, start;
  logic ctrl_wr, key_wr, other_acc, stat_wr;

  assign rst_any   = por_rst | warm_rst;
  assign ctrl_wr   = bus_wr && bus_addr == A_CTRL;
  assign key_wr    = bus_wr && bus_addr == A_KEY;
  assign stat_wr   = bus_wr && bus_addr == A_STAT;
  assign other_acc = (bus_wr || bus_rd) && bus_addr != A_KEY;
  assign start     = ctrl_wr && bus_wdata[B_WR] && wren_q && armed && !busy;

  nvu_key_seq u_key (
    .clk(clk), .rst(rst_any), .key_wr(key_wr), .other_acc(other_acc),
    .key_data(bus_wdata), .armed(armed)
  );

  nvu_busy_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
    .clk(clk), .rst(rst_any), .start(start), .busy(busy), .fin(fin)
  );

  // control, status and error state
  always_ff @(posedge clk) begin
    if (por_rst) begin
      {prog_q, cfg_q, erase_q, wren_q, err_q, done_q} <= '0;
      {stall_q, start_q, rd_q} <= '0;
    end else if (warm_rst) begin
      {prog_q, cfg_q, erase_q, wren_q, done_q} <= '0;
      {stall_q, start_q, rd_q} <= '0;
      if (busy) err_q <= 1'b1;
    end else begin
      start_q <= start;
      rd_q    <= ctrl_wr && bus_wdata[B_RD];
      if (ctrl_wr) begin
        wren_q <= bus_wdata[B_WREN];
        if (!bus_wdata[B_ERR]) err_q <= 1'b0;
        if (!busy) begin
          prog_q  <= bus_wdata[B_PROG];
          cfg_q   <= bus_wdata[B_CFG];
          erase_q <= bus_wdata[B_ERASE];
        end
      end
      if (start)    stall_q <= bus_wdata[B_PROG];
      else if (fin) stall_q <= 1'b0;
      if (fin)                          done_q <= 1'b1;
      else if (stat_wr && bus_wdata[0]) done_q <= 1'b0;
    end
  end

  // pointer bytes
  always_ff @(posedge clk) begin
    if (rst_any) begin
      ptr_q <= '0;
    end else begin
      for (int i = 0; i < PB; i++) begin
        if (bus_wr && bus_addr == A_PTR0 + ADDR_W'(i))
          ptr_q[i*8 +: 8] <= bus_wdata & PTR_MASK[i*8 +: 8];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_CTRL)
      rd_mux = {prog_q, cfg_q, 1'b0, erase_q, err_q, wren_q, busy, 1'b0};
    else if (bus_addr == A_STAT)
      rd_mux = {7'b0, done_q};
    else
      for (int i = 0; i < PB; i++)
        if (bus_addr == A_PTR0 + ADDR_W'(i)) rd_mux = ptr_q[i*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst_any)     bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign host_stall = stall_q;
  assign mem_start  = start_q;
  assign mem_rd     = rd_q;
  assign mem_prog   = prog_q;
  assign mem_erase  = erase_q;
  assign mem_addr   = ptr_q[PTR_W-1:0];
  assign mem_cfg    = cfg_q | ptr_q[PTR_W-1];
  assign irq_done   = done_q;

  // R2: key location never returns data
  assert_key_reads_zero_R2: assert property (@(posedge clk) disable iff (rst_any)
    (bus_rd && bus_addr == A_KEY) |=> bus_rdata == 8'h00);
  // R6: every start was preceded by an enabled state
  assert_start_needs_wren_R6: assert property (@(posedge clk) disable iff (rst_any)
    $rose(busy) |-> $past(wren_q));
  // R7: stall only inside a busy interval
  assert_stall_in_busy_R7: assert property (@(posedge clk) disable iff (rst_any)
    host_stall |-> busy);
  // R9: an aborted operation leaves the error flag set
  assert_abort_sets_err_R9: assert property (@(posedge clk) disable iff (por_rst)
    (warm_rst && busy) |=> err_q);
  // R10: selects frozen while running
  assert_sel_frozen_R10: assert property (@(posedge clk) disable iff (rst_any)
    (busy && $past(busy)) |-> ($stable(prog_q) && $stable(erase_q)));
endmodule

// File: tb/tb_nvm_unlock_ctrl.sv
module tb_nvm_unlock_ctrl;
  localparam int W = 20;
  logic clk = 1'b0;
  logic por_rst = 1'b1, warm_rst = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic host_stall, mem_start, mem_rd, mem_prog, mem_cfg, mem_erase, irq_done;
  logic [21:0] mem_addr;
  int n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  nvm_unlock_ctrl #(.PTR_W(22), .WR_CYCLES(W)) dut (
    .clk(clk), .por_rst(por_rst), .warm_rst(warm_rst), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .host_stall(host_stall), .mem_start(mem_start),
    .mem_rd(mem_rd), .mem_prog(mem_prog), .mem_cfg(mem_cfg),
    .mem_erase(mem_erase), .mem_addr(mem_addr), .irq_done(irq_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic unlock();
    wr(3'd1, 8'h55); wr(3'd1, 8'hAA);
  endtask

  task automatic pulse_warm();
    warm_rst = 1'b1; @(posedge clk); @(negedge clk); warm_rst = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 4 * W && (host_stall || dut.mem_start); k++) @(negedge clk);
    repeat (W + 2) @(negedge clk);
  endtask

  // {is_read, addr, data, expected}
  localparam logic [19:0] VEC [12] = '{
    {1'b0, 3'd2, 8'h12, 8'h00}, {1'b0, 3'd3, 8'h34, 8'h00},
    {1'b0, 3'd4, 8'hFF, 8'h00}, {1'b1, 3'd2, 8'h00, 8'h12},
    {1'b1, 3'd3, 8'h00, 8'h34}, {1'b1, 3'd4, 8'h00, 8'h3F},
    {1'b1, 3'd1, 8'h00, 8'h00}, {1'b0, 3'd1, 8'h55, 8'h00},
    {1'b1, 3'd1, 8'h00, 8'h00}, {1'b0, 3'd0, 8'h74, 8'h00},
    {1'b1, 3'd0, 8'h00, 8'h54}, {1'b1, 3'd5, 8'h00, 8'h00}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    por_rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 stall", host_stall, 0);
    check("R1 irq", irq_done, 0);
    check("R1 addr", mem_addr, 0);
    rd(3'd0, rv); check("R1 ctrl", rv, 0);

    // R2 vector walk
    foreach (VEC[i]) begin
      if (VEC[i][19]) begin
        rd(VEC[i][18:16], rv);
        check($sformatf("R2 vec%0d", i), rv, VEC[i][7:0]);
      end else wr(VEC[i][18:16], VEC[i][15:8]);
    end
    // R10 pointer and config select
    check("R10 addr", mem_addr, 22'h3F3412);
    check("R10 cfg via bit21", mem_cfg, 1);
    check("R10 erase", mem_erase, 1);
    wr(3'd4, 8'h00); wr(3'd0, 8'h00);
    check("R10 cfg clear", mem_cfg, 0);
    // R11 read start pulse
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h01;
    @(posedge clk); @(negedge clk); bus_wr = 1'b0;
    check("R11 mem_rd pulse", mem_rd, 1);
    @(negedge clk);
    check("R11 mem_rd one cycle", mem_rd, 0);
    rd(3'd0, rv); check("R11 bit0 reads 0", rv, 0);

    // R6 enable and start together
    unlock(); wr(3'd0, 8'h86);
    check("R6 no start", mem_start, 0);
    rd(3'd0, rv); check("R6 bit1", rv[1], 0);

    // R3 + R7 program write
    wr(3'd0, 8'h84); unlock(); wr(3'd0, 8'h86);
    check("R3 mem_start", mem_start, 1);
    n = 0;
    while (host_stall && n < 4 * W) begin n++; @(negedge clk); end
    check("R7 stall length", n, W);
    check("R8 irq set", irq_done, 1);
    rd(3'd0, rv); check("R7 bit1 cleared", rv[1], 0);
    wr(3'd5, 8'h01); check("R8 clear", irq_done, 0);

    // R5 unlock consumed
    wr(3'd0, 8'h86);
    check("R5 no restart", mem_start, 0);
    check("R5 no stall", host_stall, 0);

    // R4 wrong key and interleaved access
    wr(3'd1, 8'h55); wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h86);
    check("R4 wrong key", mem_start, 0);
    wr(3'd1, 8'h55); rd(3'd2, rv); wr(3'd1, 8'hAA); wr(3'd0, 8'h86);
    check("R4 interleaved read", mem_start, 0);
    rd(3'd0, rv); check("R4 bit1", rv[1], 0);

    // R7 data write: no stall, bit1 held; R8 set wins over clear
    unlock(); wr(3'd0, 8'h06);
    check("R7 data no stall", host_stall, 0);
    repeat (W - 1) @(negedge clk);
    wr(3'd5, 8'h01);
    check("R8 set wins", irq_done, 1);
    wr(3'd5, 8'h01);

    // R9 abort on warm reset at final busy edge, done not set
    wr(3'd0, 8'h04); unlock(); wr(3'd0, 8'h06);
    repeat (W - 1) @(negedge clk);
    pulse_warm();
    check("R9 no done on abort", irq_done, 0);
    rd(3'd0, rv); check("R9 err set", rv, 8'h08);
    pulse_warm();
    rd(3'd0, rv); check("R9 err kept", rv, 8'h08);
    wr(3'd0, 8'h08); rd(3'd0, rv); check("R9 write1 keeps", rv, 8'h08);
    wr(3'd0, 8'h00); rd(3'd0, rv); check("R9 sw clear", rv, 8'h00);
    // R9 program abort mid-way, then power-on clears
    wr(3'd0, 8'h84); unlock(); wr(3'd0, 8'h86);
    repeat (3) @(negedge clk);
    pulse_warm();
    check("R9 stall released", host_stall, 0);
    rd(3'd0, rv); check("R9 err mid", rv[3], 1);
    por_rst = 1'b1; @(negedge clk); por_rst = 1'b0; @(negedge clk);
    rd(3'd0, rv); check("R9 por clears", rv, 0);
    wr(3'd0, 8'h08); rd(3'd0, rv); check("R9 write1 no set", rv[3], 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule